// File: doc/BRIEF.md
# Asynchronous Static RAM Byte Controller

This block sits between an on-chip client and an external asynchronous static RAM that holds 131,072 bytes. The client presents a byte read or byte write on a request/acknowledge port. The controller turns each request into a cycle on the memory pins. Those pins are a 17-bit address, a low-true and a high-true chip select, a low-true write strobe, a low-true output strobe and a shared 8-bit tri-state data bus.

The length of each phase is fixed when the design is elaborated. Every nanosecond limit of the memory becomes a count of clock cycles, rounded up against a clock-period parameter. The output strobe is never active during a write, so the memory and the controller cannot drive the bus at the same time. A write always ends when the write strobe rises while both chip selects are still active.

Top module: `sramc_top`

## Requirements
- R1: While reset is held, the chip is deselected (low-true select 1, high-true select 0), both strobes are 1, the bus is released and the acknowledge is 0.
- R2: A read keeps both selects active, the write strobe at 1 and the output strobe at 0 for exactly max(ceil(tAA), ceil(tRC), ceil(tDOE)) cycles, which is 7 at the defaults. The byte on the bus at the end of that window is returned on the read-data port when the acknowledge is presented.
- R3: A write holds the write strobe at 0 for exactly max(ceil(tPWE), ceil(tSD), ceil(tAW)-1, ceil(tWC)-2) cycles, which is 5 at the defaults. The write strobe is only ever 0 while both selects are active. The addressed byte then holds the request's data.
- R4: The output strobe is 1 in every cycle in which the write strobe is 0.
- R5: The controller drives the bus with the request's write data while the write strobe is 0 and for one cycle after it rises, and in no other cycle.
- R6: Every write ends with the write strobe rising while both selects are still active.
- R7: The acknowledge is a one-cycle pulse, given exactly once per request. No new request is taken in the cycle that carries the acknowledge.
- R8: The address pins hold the request's address, unchanged, for as long as the selects are active within one cycle.
- R9: At least one cycle with both strobes at 1 separates the end of a read from the start of the write pulse that follows it.
- R10: Every access keeps the selects active for at least ceil(tWC) = 7 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present; held until the acknowledge |
| reqWrite | input | 1 | 1 for a write, 0 for a read |
| reqAddr | input | 17 | Byte address |
| reqWdata | input | 8 | Write data |
| reqAck | output | 1 | One-cycle completion pulse |
| rspRdata | output | 8 | Read data, valid with the acknowledge |
| memAddr | output | 17 | Memory address pins |
| memCe1N | output | 1 | Low-true chip select |
| memCe2 | output | 1 | High-true chip select |
| memWeN | output | 1 | Low-true write strobe |
| memOeN | output | 1 | Low-true output strobe |
| memData | inout | 8 | Shared data bus |

## Verification
A wrong state or a wrong counter value shows up at the pins within the access in which it happens. The strobe windows come out one cycle too long or too short, or the output strobe falls during a write pulse. A write can also end with the selects already gone, which leaves the wrong byte in memory. That wrong byte shows up on the next read of the same address. A lost or doubled acknowledge shows up within one request as a hang or as an acknowledge count that no longer matches the requests issued.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WR_ADDR,
    ST_WR_PULSE,
    ST_WR_HOLD
  } sramcState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;   // latch the client request
    logic select;    // both chip selects active
    logic outEn;     // output strobe active
    logic writeEn;   // write strobe active
    logic driveBus;  // controller drives the data bus
    logic capture;   // sample the data bus into read data
  } sramcStrobe_t;

  function automatic int cdiv(input int t, input int p);
    return (t + p - 1) / p;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sramc_ctrl.sv
module sramc_ctrl
  import sramc_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_RC  = 70,
  parameter int T_AA  = 70,
  parameter int T_DOE = 35,
  parameter int T_WC  = 70,
  parameter int T_PWE = 50,
  parameter int T_AW  = 60,
  parameter int T_SD  = 30
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqWrite,
  output sramcStrobe_t strobes,
  output logic         reqAck
);

  localparam int RD_CYC = imax(1, imax(cdiv(T_AA, CLK_PERIOD_NS),
                               imax(cdiv(T_RC, CLK_PERIOD_NS), cdiv(T_DOE, CLK_PERIOD_NS))));
  localparam int WP_CYC = imax(1, imax(imax(cdiv(T_PWE, CLK_PERIOD_NS), cdiv(T_SD, CLK_PERIOD_NS)),
                               imax(cdiv(T_AW, CLK_PERIOD_NS) - 1, cdiv(T_WC, CLK_PERIOD_NS) - 2)));
  localparam int CNT_W  = $clog2(imax(RD_CYC, WP_CYC) + 1);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LAST = CNT_W'(WP_CYC - 1);

  sramcState_t      state;
  logic [CNT_W-1:0] cnt;
  logic             ackQ;
  logic             accept;
  logic             cntDone;

  assign accept  = (state == ST_IDLE) && reqValid && !ackQ;
  assign cntDone = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      ackQ  <= 1'b0;
    end else begin
      ackQ <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          state <= reqWrite ? ST_WR_ADDR : ST_READ;
          cnt   <= reqWrite ? '0 : RD_LAST;
        end
        ST_READ: if (cntDone) begin
          state <= ST_IDLE;
          ackQ  <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
        ST_WR_ADDR: begin
          state <= ST_WR_PULSE;
          cnt   <= WP_LAST;
        end
        ST_WR_PULSE: if (cntDone) begin
          state <= ST_WR_HOLD;
        end else begin
          cnt <= cnt - 1'b1;
        end
        ST_WR_HOLD: begin
          state <= ST_IDLE;
          ackQ  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes          = '0;
    strobes.loadReq  = accept;
    strobes.select   = (state != ST_IDLE);
    strobes.outEn    = (state == ST_READ);
    strobes.writeEn  = (state == ST_WR_PULSE);
    strobes.driveBus = (state == ST_WR_PULSE) || (state == ST_WR_HOLD);
    strobes.capture  = (state == ST_READ) && cntDone;
  end

  assign reqAck = ackQ;

endmodule

// File: rtl/sramc_datapath.sv
module sramc_datapath
  import sramc_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sramcStrobe_t      strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memWeN,
  output logic              memOeN,
  inout  wire  [DATA_W-1:0] memData
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
    end else begin
      if (strobes.loadReq) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (strobes.capture) rdataQ <= memData;
    end
  end

  assign memAddr  = addrQ;
  assign memCe1N  = !strobes.select;
  assign memCe2   = strobes.select;
  assign memWeN   = !strobes.writeEn;
  assign memOeN   = !strobes.outEn;
  assign memData  = strobes.driveBus ? wdataQ : {DATA_W{1'bz}};
  assign rspRdata = rdataQ;

endmodule

// File: rtl/sramc_top.sv
module sramc_top
  import sramc_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_RC  = 70,
  parameter int T_AA  = 70,
  parameter int T_DOE = 35,
  parameter int T_WC  = 70,
  parameter int T_PWE = 50,
  parameter int T_AW  = 60,
  parameter int T_SD  = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqAck,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memWeN,
  output logic              memOeN,
  inout  wire  [DATA_W-1:0] memData
);

  sramcStrobe_t strobes;

  sramc_ctrl #(
    .CLK_PERIOD_NS(CLK_PERIOD_NS),
    .T_RC(T_RC), .T_AA(T_AA), .T_DOE(T_DOE),
    .T_WC(T_WC), .T_PWE(T_PWE), .T_AW(T_AW), .T_SD(T_SD)
  ) ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .strobes(strobes), .reqAck(reqAck)
  );

  sramc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rspRdata(rspRdata),
    .memAddr(memAddr), .memCe1N(memCe1N), .memCe2(memCe2),
    .memWeN(memWeN), .memOeN(memOeN), .memData(memData)
  );

endmodule

// File: rtl/sramc_checker.sv
module sramc_checker #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqAck,
  input logic              memCe1N,
  input logic              memCe2,
  input logic              memWeN,
  input logic              memOeN,
  input logic [ADDR_W-1:0] memAddr,
  input logic              driveBus
);

  // R4
  oe_idle_in_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memOeN);

  // R3
  write_selected_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (!memCe1N && memCe2));

  // R6
  write_end_selected_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (!memCe1N && memCe2));

  // R7
  ack_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> !reqAck);

  // R2
  read_strobes_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> (memWeN && !memCe1N && memCe2));

  // R8
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memCe1N && $past(!memCe1N)) |-> $stable(memAddr));

  // R5
  drive_no_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    driveBus |-> (memOeN && !memCe1N));

  // R5
  drive_starts_with_we_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(driveBus) |-> !memWeN);

  // R1
  selects_agree_chk: assert property (@(posedge clk) disable iff (!rstN)
    memCe1N == !memCe2);

endmodule

bind sramc_top sramc_checker #(.ADDR_W(ADDR_W)) chk (
  .clk(clk), .rstN(rstN), .reqAck(reqAck),
  .memCe1N(memCe1N), .memCe2(memCe2), .memWeN(memWeN), .memOeN(memOeN),
  .memAddr(memAddr), .driveBus(strobes.driveBus)
);

// File: tb/sramc_top_test.sv
module sramc_top_test;

  localparam int CLK_NS  = 10;
  localparam int RD_EXP  = 7;  // ceil(70/10) read window
  localparam int WP_EXP  = 5;  // max(5, 3, 6-1, 7-2) write pulse
  localparam int WC_MIN  = 7;  // ceil(70/10)

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [16:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        reqAck;
  logic [7:0]  rspRdata;
  logic [16:0] memAddr;
  logic        memCe1N, memCe2, memWeN, memOeN;
  wire  [7:0]  memData;

  int vectors = 0;
  int fails = 0;
  int acks = 0;
  int issued = 0;
  bit finished = 1'b0;

  logic [7:0] model [int];
  logic [7:0] expMem [int];
  logic [7:0] modelOut;
  logic       modelDrive;
  logic [16:0] curAddr = '0;
  logic [7:0]  curWdata = '0;

  always #(CLK_NS/2) clk = ~clk;

  sramc_top uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqAck(reqAck), .rspRdata(rspRdata),
    .memAddr(memAddr), .memCe1N(memCe1N), .memCe2(memCe2),
    .memWeN(memWeN), .memOeN(memOeN), .memData(memData)
  );

  // memory model: drives in read mode, stores on write strobe rise
  assign modelDrive = !memCe1N && memCe2 && !memOeN && memWeN;
  always @(memAddr or memOeN or memWeN or memCe1N) begin
    modelOut = model.exists(int'(memAddr)) ? model[int'(memAddr)] : 8'h00;
  end
  assign memData = modelDrive ? modelOut : 8'hzz;
  always @(posedge memWeN) begin
    if (!memCe1N && memCe2) model[int'(memAddr)] = memData;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] expRead(input logic [16:0] a);
    return expMem.exists(int'(a)) ? expMem[int'(a)] : 8'h00;
  endfunction

  // pin monitor, sampled away from the rising edge
  logic prevWeN = 1'b1, prevOeN = 1'b1, prevSel = 1'b0, prevAck = 1'b0;
  logic [16:0] prevAddr = '0;
  int weRun = 0, oeRun = 0, selRun = 0, quietRun = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      // R1 reset state
      check(memCe1N && !memCe2 && memWeN && memOeN && !reqAck, "R1",
            {memCe1N, memCe2, memWeN, memOeN, reqAck}, 5'b10110);
    end else begin
      logic sel;
      sel = !memCe1N && memCe2;
      if (reqAck) acks++;
      if (reqAck && prevAck) check(1'b0, "R7 ack width", 2, 1);
      if (!memWeN && prevWeN) check(quietRun >= 1, "R9 turnaround", quietRun, 1);
      if (memWeN && !prevWeN) begin
        check(weRun == WP_EXP, "R3 write pulse", weRun, WP_EXP);
        check(sel, "R6 select at write end", sel, 1);
      end
      if (memOeN && !prevOeN) check(oeRun == RD_EXP, "R2 read window", oeRun, RD_EXP);
      if (!sel && prevSel) check(selRun >= WC_MIN, "R10 cycle length", selRun, WC_MIN);
      if (!memWeN) begin
        check(memOeN, "R4 output strobe in write", memOeN, 1);
        check(memData == curWdata, "R5 bus data", memData, curWdata);
      end
      if (sel) check(memAddr == curAddr, "R8 address", memAddr, curAddr);
      if (sel && prevSel) check(memAddr == prevAddr, "R8 stable", memAddr, prevAddr);
      weRun    = !memWeN ? weRun + 1 : 0;
      oeRun    = !memOeN ? oeRun + 1 : 0;
      selRun   = sel ? selRun + 1 : 0;
      quietRun = (memOeN && memWeN) ? quietRun + 1 : 0;
    end
    prevWeN = memWeN; prevOeN = memOeN; prevSel = !memCe1N && memCe2;
    prevAck = reqAck; prevAddr = memAddr;
  end

  task automatic doReq(input bit wr, input logic [16:0] a, input logic [7:0] d);
    int waitCyc;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    curAddr = a; curWdata = d;
    issued++;
    waitCyc = 0;
    do begin
      @(negedge clk);
      waitCyc++;
    end while (!reqAck && waitCyc < 100);
    reqValid = 1'b0;
    check(reqAck, "R7 ack arrives", reqAck, 1);
    if (wr) begin
      expMem[int'(a)] = d;
      check(model.exists(int'(a)) && model[int'(a)] == d, "R3 stored byte",
            model.exists(int'(a)) ? model[int'(a)] : 0, d);
    end else begin
      check(rspRdata == expRead(a), "R2 read data", rspRdata, expRead(a));
    end
    @(negedge clk);
    check(acks == issued, "R7 one ack per request", acks, issued);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4127));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // directed corners
    doReq(1'b0, 17'h00055, 8'h00);          // R2 unwritten location
    doReq(1'b1, 17'h00000, 8'hA5);          // R3 lowest address
    doReq(1'b1, 17'h1FFFF, 8'h3C);          // R3 highest address
    doReq(1'b0, 17'h00000, 8'h00);          // R2
    doReq(1'b0, 17'h1FFFF, 8'h00);          // R2
    doReq(1'b1, 17'h1FFFF, 8'hFF);          // R9 read then write
    doReq(1'b0, 17'h1FFFF, 8'h00);
    doReq(1'b1, 17'h0AAAA, 8'h00);          // zero data
    doReq(1'b0, 17'h0AAAA, 8'h00);
    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [16:0] a;
      bit wr;
      wr = ($urandom % 2) == 0;
      a  = (($urandom % 4) == 0) ? 17'($urandom) : 17'($urandom % 24);
      doReq(wr, a, 8'($urandom));
    end
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule